// File: doc/BRIEF.md
# Two-Level Ring-Oscillator Phase Digitizer

The block turns the running phase of an external multi-phase ring oscillator into a digital word once per sample clock. A coarse part counts half-periods of one reference phase: every rising and every falling edge adds one step of pi radians. A fine part reads the levels of all oscillator phases at the sample instant and finds where the level pattern changes. That gives the remaining phase inside the current half-period in steps of pi/N. The two parts are joined into one phase word. The difference between two consecutive words is the frequency code, which is proportional to the oscillator's control input.

The coarse edge counters run in the oscillator's own clock domain and hand their value over as Gray code. The oscillator phases and the Gray counts pass through a two-stage synchronizer into the sample domain. The counters have no reset of their own, because the oscillator may be idle while the block is held in reset. Instead, the first coarse value taken after reset is stored as a base and subtracted from every later value. The result is the same as clearing the counters.

A small sequencer steps through four states after reset. `ST_FILL_A` moves to `ST_FILL_B` on the first sample edge and `ST_FILL_B` moves to `ST_PRIME` on the second, while the synchronizer fills. `ST_PRIME` stores the base and publishes the first phase word on the third edge, then moves to `ST_RUN`. `ST_RUN` keeps that state until the next reset and publishes a phase word and a frequency code on every edge.

Top module: `vpq_phase_quantizer`

## Requirements
- R1: The coarse field (bits WORD_W-1 down to log2(N) of the phase word) counts both the rising and the falling edges of phase input 0 since the base sample. Each edge is one half-period of pi radians.
- R2: The fine field (the low log2(N) bits) is N-1 minus the number of phase inputs 1..N-1 whose sampled level differs from phase input 0. Input k lags input 0 by k*pi/N, so the fine field ranges from 0 to N-1 and counts pi/N steps into the current half-period.
- R3: The phase word equals the coarse count times N plus the fine code, taken modulo 2^WORD_W, relative to the coarse count at the first sample after reset.
- R4: The phase inputs sampled at sample edge e appear on the phase word just after edge e+2.
- R5: The frequency code is the current phase word minus the previous phase word, modulo 2^WORD_W. It stays correct when the phase word wraps past its maximum.
- R6: While the reset input is high at a sample edge, the phase word, the frequency code and both valid flags are zero after that edge.
- R7: After reset is released, the phase valid flag first rises on the third sample edge and the frequency valid flag on the fourth. Both stay high until the next reset, and frequency valid is never high without phase valid.
- R8: When the oscillator is stopped, the frequency code is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| ph_in | input | NUM_PH | Oscillator phase levels; bit 0 is the reference phase, bit k lags it by k*pi/N |
| phase_word | output | CNT_W+log2(NUM_PH) | Combined coarse and fine phase word |
| phase_valid | output | 1 | Phase word is valid |
| freq_code | output | CNT_W+log2(NUM_PH) | Difference of consecutive phase words, modulo the word width |
| freq_valid | output | 1 | Frequency code is valid |

## Verification
Two functions can land in the same sample cycle. One is the fine field rolling from N-1 back to 0. The other is the coarse field stepping, and in the same cycle the phase word may also wrap past 2^WORD_W while a frequency code is formed across the wrap. These are provoked by running the behavioural oscillator at several tick periods that are unrelated to the sample period. The sample instant then falls just before and just after reference-phase edges, and the word wraps many times over a run. A reset while the oscillator is running also makes the base capture coincide with a non-zero coarse count. The results are judged each cycle against a model that counts oscillator ticks: it expects the word to be the tick count at the sample two edges earlier, less the base, and the frequency code to be the tick difference between samples.

// File: rtl/vpq_pkg.sv
`timescale 1ns/1ps
package vpq_pkg;

    // Sequencer states of the phase digitizer
    typedef enum logic [1:0] {
        ST_FILL_A = 2'd0,   // first synchronizer stage filling
        ST_FILL_B = 2'd1,   // second synchronizer stage filling
        ST_PRIME  = 2'd2,   // base capture, first word
        ST_RUN    = 2'd3    // steady conversion
    } vpq_state_e;

    localparam int VPQ_SYNC_STAGES = 2;

endpackage

// File: rtl/vpq_gray_edge_counter.sv
`timescale 1ns/1ps
// Counts one edge polarity of the reference phase in its own domain and
// presents the count as Gray code so that only one bit changes per edge.
module vpq_gray_edge_counter #(
    parameter int CNT_W     = 8,
    parameter bit FALL_EDGE = 1'b0
) (
    input  logic             ph_ref,
    output logic [CNT_W-1:0] gray_o
);

    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nxt;
    logic [CNT_W-1:0] gray_q;

    assign bin_nxt = bin_q + CNT_W'(1);
    assign gray_o  = gray_q;

    generate
        if (FALL_EDGE) begin : g_fall
            always_ff @(negedge ph_ref) begin
                bin_q  <= bin_nxt;
                gray_q <= bin_nxt ^ (bin_nxt >> 1);
            end
        end else begin : g_rise
            always_ff @(posedge ph_ref) begin
                bin_q  <= bin_nxt;
                gray_q <= bin_nxt ^ (bin_nxt >> 1);
            end
        end
    endgenerate

endmodule

// File: rtl/vpq_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer bank into the sample domain.
module vpq_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;

endmodule

// File: rtl/vpq_gray_to_bin.sv
`timescale 1ns/1ps
// Gray to binary: each binary bit is the parity of the Gray bits at and above it.
module vpq_gray_to_bin #(
    parameter int W = 8
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);

    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_o[i] = ^(gray_i >> i);
        end
    end

endmodule

// File: rtl/vpq_fine_decode.sv
`timescale 1ns/1ps
// Residual-phase decoder: locates the level transition in the sampled
// phase pattern by counting phases that disagree with the reference.
module vpq_fine_decode #(
    parameter int NUM_PH = 8,
    localparam int LOGN  = $clog2(NUM_PH)
) (
    input  logic [NUM_PH-1:0] ph_i,
    output logic [LOGN-1:0]   fine_o
);

    logic [LOGN-1:0] disagree;

    always_comb begin
        disagree = '0;
        for (int k = 1; k < NUM_PH; k++) begin
            disagree = disagree + LOGN'(ph_i[k] ^ ph_i[0]);
        end
        fine_o = LOGN'(NUM_PH - 1) - disagree;
    end

endmodule

// File: rtl/vpq_phase_quantizer.sv
`timescale 1ns/1ps
module vpq_phase_quantizer #(
    parameter int  NUM_PH = 8,
    parameter int  CNT_W  = 8,
    localparam int LOGN   = $clog2(NUM_PH),
    localparam int WORD_W = CNT_W + LOGN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PH-1:0] ph_in,
    output logic [WORD_W-1:0] phase_word,
    output logic              phase_valid,
    output logic [WORD_W-1:0] freq_code,
    output logic              freq_valid
);
    import vpq_pkg::*;

    localparam int SYNC_W = 2 * CNT_W + NUM_PH;

    generate
        if ((1 << LOGN) != NUM_PH) begin : g_bad_num_ph
            $error("NUM_PH must be a power of two");
        end
    endgenerate

    // ---------------- coarse edge counters (oscillator domain) ----------
    logic [CNT_W-1:0] gray_rise;
    logic [CNT_W-1:0] gray_fall;

    vpq_gray_edge_counter #(.CNT_W(CNT_W), .FALL_EDGE(1'b0)) u_cnt_rise (
        .ph_ref (ph_in[0]),
        .gray_o (gray_rise)
    );

    vpq_gray_edge_counter #(.CNT_W(CNT_W), .FALL_EDGE(1'b1)) u_cnt_fall (
        .ph_ref (ph_in[0]),
        .gray_o (gray_fall)
    );

    // ---------------- synchronizer into sample domain -------------------
    logic [SYNC_W-1:0] sync_d;
    logic [SYNC_W-1:0] sync_q;
    logic [CNT_W-1:0]  gray_rise_s;
    logic [CNT_W-1:0]  gray_fall_s;
    logic [NUM_PH-1:0] ph_s;

    assign sync_d = {gray_rise, gray_fall, ph_in};

    vpq_sync2 #(.WIDTH(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sync_d),
        .q_o (sync_q)
    );

    assign gray_rise_s = sync_q[SYNC_W-1 -: CNT_W];
    assign gray_fall_s = sync_q[NUM_PH +: CNT_W];
    assign ph_s        = sync_q[NUM_PH-1:0];

    // ---------------- decode --------------------------------------------
    logic [CNT_W-1:0] bin_rise;
    logic [CNT_W-1:0] bin_fall;
    logic [CNT_W-1:0] coarse_raw;
    logic [CNT_W-1:0] base_q;
    logic [LOGN-1:0]  fine;
    logic [WORD_W-1:0] word_rel;

    vpq_gray_to_bin #(.W(CNT_W)) u_g2b_rise (
        .gray_i (gray_rise_s),
        .bin_o  (bin_rise)
    );

    vpq_gray_to_bin #(.W(CNT_W)) u_g2b_fall (
        .gray_i (gray_fall_s),
        .bin_o  (bin_fall)
    );

    vpq_fine_decode #(.NUM_PH(NUM_PH)) u_fine (
        .ph_i   (ph_s),
        .fine_o (fine)
    );

    assign coarse_raw = bin_rise + bin_fall;
    assign word_rel   = {coarse_raw - base_q, fine};

    // ---------------- sequencer -----------------------------------------
    vpq_state_e state_q;
    vpq_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL_A;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL_A: state_d = ST_FILL_B;
            ST_FILL_B: state_d = ST_PRIME;
            ST_PRIME:  state_d = ST_RUN;
            ST_RUN:    state_d = ST_RUN;
            default:   state_d = ST_FILL_A;
        endcase
    end

    // ---------------- outputs -------------------------------------------
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q      <= '0;
            phase_word  <= '0;
            phase_valid <= 1'b0;
            freq_code   <= '0;
            freq_valid  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_PRIME: begin
                    base_q      <= coarse_raw;
                    phase_word  <= {{CNT_W{1'b0}}, fine};
                    phase_valid <= 1'b1;
                end
                ST_RUN: begin
                    phase_word  <= word_rel;
                    freq_code   <= word_rel - phase_word;
                    freq_valid  <= 1'b1;
                end
                default: begin
                    phase_valid <= 1'b0;
                    freq_valid  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/vpq_phase_quantizer_chk.sv
`timescale 1ns/1ps
module vpq_phase_quantizer_chk #(
    parameter int WORD_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] phase_word,
    input logic              phase_valid,
    input logic [WORD_W-1:0] freq_code,
    input logic              freq_valid
);

    // R6
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!phase_valid && !freq_valid &&
                        phase_word == '0 && freq_code == '0));

    // R7
    valid_order_chk: assert property (@(posedge clk) disable iff (rst)
        freq_valid |-> phase_valid);

    // R7
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        phase_valid |=> phase_valid);

    // R7
    freq_after_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(freq_valid) |-> $past(phase_valid));

    // R5
    freq_diff_chk: assert property (@(posedge clk) disable iff (rst)
        freq_valid |-> (freq_code == WORD_W'(phase_word - $past(phase_word))));

endmodule

bind vpq_phase_quantizer vpq_phase_quantizer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .phase_word  (phase_word),
    .phase_valid (phase_valid),
    .freq_code   (freq_code),
    .freq_valid  (freq_valid)
);

// File: tb/vpq_phase_quantizer_tb.sv
`timescale 1ns/1ps
module vpq_phase_quantizer_tb_top;

    localparam int NUM_PH = 8;
    localparam int CNT_W  = 8;
    localparam int LOGN   = 3;
    localparam int WORD_W = CNT_W + LOGN;
    localparam int MASK   = (1 << WORD_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_PH-1:0] ph;
    logic [WORD_W-1:0] phase_word;
    logic              phase_valid;
    logic [WORD_W-1:0] freq_code;
    logic              freq_valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    vpq_phase_quantizer #(.NUM_PH(NUM_PH), .CNT_W(CNT_W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .ph_in       (ph),
        .phase_word  (phase_word),
        .phase_valid (phase_valid),
        .freq_code   (freq_code),
        .freq_valid  (freq_valid)
    );

    // ---------------- behavioural ring oscillator -----------------------
    // Total phase in ticks of pi/N; phase k is high when (t-k) mod 2N < N.
    int t_ticks  = 0;
    int step_ps  = 370;
    bit osc_run  = 1'b0;
    bit osc_zero = 1'b0;

    function automatic logic [NUM_PH-1:0] ph_of(int t);
        logic [NUM_PH-1:0] v;
        for (int k = 0; k < NUM_PH; k++) begin
            v[k] = ((((t - k) % (2 * NUM_PH)) + 2 * NUM_PH) % (2 * NUM_PH)) < NUM_PH;
        end
        return v;
    endfunction

    initial begin
        ph = ph_of(0);
        #0.003;   // keeps every oscillator event off the sample edges
        forever begin
            #(step_ps * 0.001);
            if (osc_zero) t_ticks = 0;
            else if (osc_run) t_ticks++;
            ph = ph_of(t_ticks);
        end
    end

    // ---------------- reference model -----------------------------------
    int tq[$];
    int nedge = 0;

    always @(posedge clk) begin
        if (rst) begin
            nedge = 0;
            tq.delete();
        end else begin
            tq.push_back(t_ticks);
            nedge++;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int base;
            int expw;
            int expf;
            chk(phase_valid == (nedge >= 3), "R7 phase_valid", phase_valid, nedge >= 3);
            chk(freq_valid == (nedge >= 4), "R7 freq_valid", freq_valid, nedge >= 4);
            if (nedge == 0) begin
                chk(phase_word == '0, "R6 phase_word in reset", phase_word, 0);
                chk(freq_code == '0, "R6 freq_code in reset", freq_code, 0);
            end
            if (nedge >= 3) begin
                base = (tq[0] / NUM_PH) * NUM_PH;
                expw = (tq[nedge-3] - base) & MASK;
                chk(int'(phase_word[WORD_W-1:LOGN]) == (expw >> LOGN), "R1 coarse field",
                    phase_word[WORD_W-1:LOGN], expw >> LOGN);
                chk(int'(phase_word[LOGN-1:0]) == (expw & (NUM_PH - 1)), "R2 fine field",
                    phase_word[LOGN-1:0], expw & (NUM_PH - 1));
                chk(int'(phase_word) == expw, "R3 R4 phase_word", phase_word, expw);
            end
            if (nedge >= 4) begin
                expf = (tq[nedge-3] - tq[nedge-4]) & MASK;
                chk(int'(freq_code) == expf, "R5 freq_code", freq_code, expf);
                if (tq[nedge-3] == tq[nedge-4])
                    chk(freq_code == '0, "R8 stopped oscillator", freq_code, 0);
            end
        end
    end

    // ---------------- stimulus ------------------------------------------
    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        wait_cycles(5);
        rst = 1'b0;
        wait_cycles(6);            // stopped oscillator right after release
        osc_run = 1'b1;
        step_ps = 370;
        wait_cycles(300);          // many word wraps
        step_ps = 1130;
        wait_cycles(200);
        step_ps = 60;
        wait_cycles(150);          // fast oscillator
        osc_run = 1'b0;
        wait_cycles(40);           // R8
        rst = 1'b1;
        osc_zero = 1'b1;
        wait_cycles(4);
        osc_zero = 1'b0;
        rst = 1'b0;
        wait_cycles(3);
        osc_run = 1'b1;
        step_ps = 7990;
        wait_cycles(120);          // about one tick per sample
        step_ps = 2510;
        wait_cycles(100);
        step_ps = 370;
        rst = 1'b1;                // reset with oscillator running: non-zero base
        wait_cycles(3);
        rst = 1'b0;
        wait_cycles(200);
        finish_run();
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

endmodule